// File: doc/BRIEF.md
# Strided and Indexed Burst Packer

This block serves one extended read burst at a time on behalf of a wide bus. A request carries a base address, an element count and two mode bits. From these the block works out where each narrow element lives in memory. With packing disabled, the elements are contiguous. With packing enabled, either a constant byte step separates consecutive elements, or an index array in memory holds each element's position relative to the base. The block fetches the elements one at a time through a simple single-element read port. It then lays them side by side on wide output beats, so a sparse gather leaves the block as a dense stream.

Two stages are kept apart. The address stage walks the burst and issues reads, and in indexed mode it first reads each index. The beat stage assembles the returned elements into beats. A bounded element FIFO sits between the two stages. The address stage takes a credit against that FIFO for every element read it has outstanding, so a stalled output never causes an overflow or a deadlock.

The request interface and the beat output are valid/ready. A request is taken only while `req_ready` is high, and `req_ready` stays low from that acceptance until the final beat of the burst has been handed over. While `beat_valid` is high and `beat_ready` is low, the beat and its flag stay frozen. The memory port issues a read when `mem_req_valid` and `mem_req_ready` are both high. The memory must answer every accepted read exactly once, in order, no earlier than the next cycle. It answers by pulsing `mem_rsp_valid` with a 32-bit little-endian word read from the requested byte address.

Top module: `gather_packer`

## Requirements
- R1: While and right after reset, `req_ready` is high and `beat_valid` and `mem_req_valid` are low.
- R2: With `req_packed` low, element i is read at `req_base + i*2`, because elements are 2 bytes wide. `req_step`, `req_indexed` and `req_idx_addr` have no effect on this.
- R3: With `req_packed` high and `req_indexed` low, element i is read at `req_base + i*req_step`. This includes a step of zero.
- R4: With both bits high, the block first reads index i at `req_idx_addr + i*s`. The size s comes from `req_step[1:0]`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. The index is the low s bytes of the response, zero-extended. The block then reads the element at `req_base + index*2`. For each element the index read comes before the element read.
- R5: An element's value is the low 16 bits of its read response. Element k of a burst lands in lane k mod 4 of beat k/4, and lane j occupies `beat_data[16j+15:16j]`.
- R6: A burst of fewer than a whole number of beats ends with a partial beat whose unused lanes are zero. `beat_last` is high on the final beat of a burst and on no other beat.
- R7: A burst carries `req_len + 1` elements. `req_ready` is low from the cycle after acceptance until the cycle after the final beat's handshake. While `req_ready` is high, neither `mem_req_valid` nor `beat_valid` is asserted.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `beat_data` and `beat_last` hold their values.
- R9: Element reads outstanding plus elements buffered never exceed the FIFO depth (4). Under a long output stall, element reads pause and no element is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | 32 | Element base byte address |
| req_len | input | 8 | Element count minus one |
| req_packed | input | 1 | Enables strided or indexed addressing |
| req_indexed | input | 1 | Selects the index array over the constant step |
| req_step | input | 16 | Byte step (strided) or index size code (indexed) |
| req_idx_addr | input | 32 | Byte address of the index array |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data returned, in order |
| mem_rsp_data | input | 32 | Little-endian word at the read address |
| beat_valid | output | 1 | Packed beat available |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_data | output | 64 | Four 16-bit lanes, element 0 lowest |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench follows the address order of indexed bursts of every index size. A design that sized or masked the index wrongly, or that skipped the index read, shows up at once as a mismatch on `mem_req_addr`. Bursts of 1, 4, 7 and 10 elements, including a zero step, exercise the partial final beat. A packer that left stale lanes or raised `beat_last` early would emit wrong data or a wrong flag there. Long output stalls are paired with random memory back-pressure and random latency. A credit leak would overflow the FIFO and drop or repeat elements in the compared beat stream. A leaky hold would break the frozen-beat check.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef enum logic [2:0] {
    AG_IDLE,
    AG_RUN,
    AG_IX_REQ,
    AG_IX_WAIT,
    AG_EL_REQ
  } ag_state_e;

  // Size code of an index entry -> bytes per entry
  function automatic logic [2:0] idx_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/gp_fifo.sv
module gp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign dout    = store_q[rd_q];
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        store_q[wr_q] <= din;
        wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
      end
      if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/gp_addr_gen.sv
module gp_addr_gen
  import gp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int MEM_W  = 32,
  parameter int ELEM_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_indexed,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_step,
  input  logic [ADDR_W-1:0] cfg_idx_addr,
  input  logic [1:0]        cfg_idx_code,
  input  logic [LEN_W:0]    cfg_total,
  input  logic [CNT_W-1:0]  fifo_cnt,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [MEM_W-1:0]  mem_rsp_data,
  output logic              elem_push,
  output logic [ELEM_W-1:0] elem_data,
  output logic [CNT_W-1:0]  inflight
);
  localparam int TOT_W      = LEN_W + 1;
  localparam int ELEM_BYTES = ELEM_W / 8;
  localparam int ELEM_SH    = $clog2(ELEM_BYTES);

  ag_state_e         state_q;
  logic [TOT_W-1:0]  issued_q;
  logic [ADDR_W-1:0] run_addr_q, ix_addr_q, el_addr_q;
  logic [CNT_W-1:0]  inflight_q;
  logic [CNT_W:0]    claim;
  logic              credit_ok, issue, issue_el, rsp_is_idx, last_issue;
  logic [MEM_W-1:0]  idx_val;

  assign claim      = {1'b0, inflight_q} + {1'b0, fifo_cnt};
  assign credit_ok  = claim < (CNT_W + 1)'(DEPTH);
  assign issue      = mem_req_valid && mem_req_ready;
  assign issue_el   = issue && (state_q == AG_RUN || state_q == AG_EL_REQ);
  assign rsp_is_idx = mem_rsp_valid && (state_q == AG_IX_WAIT) && (inflight_q == '0);
  assign elem_push  = mem_rsp_valid && !rsp_is_idx;
  assign elem_data  = mem_rsp_data[ELEM_W-1:0];
  assign inflight   = inflight_q;
  assign last_issue = (issued_q == cfg_total - TOT_W'(1));

  always_comb begin
    case (cfg_idx_code)
      2'd0:    idx_val = MEM_W'(mem_rsp_data[7:0]);
      2'd1:    idx_val = MEM_W'(mem_rsp_data[15:0]);
      default: idx_val = mem_rsp_data;
    endcase
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    case (state_q)
      AG_RUN:    begin mem_req_valid = credit_ok; mem_req_addr = run_addr_q; end
      AG_IX_REQ: begin mem_req_valid = 1'b1;      mem_req_addr = ix_addr_q;  end
      AG_EL_REQ: begin mem_req_valid = credit_ok; mem_req_addr = el_addr_q;  end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= AG_IDLE;
      issued_q   <= '0;
      run_addr_q <= '0;
      ix_addr_q  <= '0;
      el_addr_q  <= '0;
      inflight_q <= '0;
    end else begin
      inflight_q <= inflight_q + CNT_W'(issue_el) - CNT_W'(elem_push);
      case (state_q)
        AG_IDLE: if (start) begin
          issued_q   <= '0;
          run_addr_q <= cfg_base;
          ix_addr_q  <= cfg_idx_addr;
          state_q    <= cfg_indexed ? AG_IX_REQ : AG_RUN;
        end
        AG_RUN: if (issue) begin
          run_addr_q <= run_addr_q + cfg_step;
          issued_q   <= issued_q + TOT_W'(1);
          if (last_issue) state_q <= AG_IDLE;
        end
        AG_IX_REQ: if (issue) begin
          ix_addr_q <= ix_addr_q + ADDR_W'(idx_bytes(cfg_idx_code));
          state_q   <= AG_IX_WAIT;
        end
        AG_IX_WAIT: if (rsp_is_idx) begin
          el_addr_q <= cfg_base + (ADDR_W'(idx_val) << ELEM_SH);
          state_q   <= AG_EL_REQ;
        end
        AG_EL_REQ: if (issue) begin
          issued_q <= issued_q + TOT_W'(1);
          state_q  <= last_issue ? AG_IDLE : AG_IX_REQ;
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gp_beat_pack.sv
module gp_beat_pack #(
  parameter int ELEM_W = 16,
  parameter int LANES  = 4,
  parameter int LEN_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W:0]          cfg_total,
  input  logic                    elem_avail,
  input  logic [ELEM_W-1:0]       elem_data,
  output logic                    elem_pop,
  output logic                    beat_valid,
  input  logic                    beat_ready,
  output logic [LANES*ELEM_W-1:0] beat_data,
  output logic                    beat_last
);
  localparam int TOT_W  = LEN_W + 1;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][ELEM_W-1:0] lanes_q;
  logic [LIDX_W-1:0]            lane_q;
  logic [TOT_W-1:0]             taken_q;
  logic                         bv_q, bl_q, last_elem, lane_full;

  assign elem_pop   = elem_avail && !bv_q;
  assign last_elem  = (taken_q == cfg_total - TOT_W'(1));
  assign lane_full  = (lane_q == LIDX_W'(LANES - 1));
  assign beat_valid = bv_q;
  assign beat_last  = bl_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign beat_data[g*ELEM_W +: ELEM_W] = lanes_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= '0;
      lane_q  <= '0;
      taken_q <= '0;
      bv_q    <= 1'b0;
      bl_q    <= 1'b0;
    end else if (start) begin
      lane_q  <= '0;
      taken_q <= '0;
    end else if (bv_q) begin
      if (beat_ready) begin
        bv_q    <= 1'b0;
        bl_q    <= 1'b0;
        lanes_q <= '0;
      end
    end else if (elem_pop) begin
      lanes_q[lane_q] <= elem_data;
      taken_q         <= taken_q + TOT_W'(1);
      if (lane_full || last_elem) begin
        bv_q   <= 1'b1;
        bl_q   <= last_elem;
        lane_q <= '0;
      end else begin
        lane_q <= lane_q + LIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/gather_packer.sv
module gather_packer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ELEM_W = 16,
  parameter int LANES  = 4,
  parameter int MEM_W  = 32,
  parameter int STEP_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_base,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_packed,
  input  logic                    req_indexed,
  input  logic [STEP_W-1:0]       req_step,
  input  logic [ADDR_W-1:0]       req_idx_addr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [MEM_W-1:0]        mem_rsp_data,
  output logic                    beat_valid,
  input  logic                    beat_ready,
  output logic [LANES*ELEM_W-1:0] beat_data,
  output logic                    beat_last
);
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int TOT_W      = LEN_W + 1;
  localparam int ELEM_BYTES = ELEM_W / 8;
  localparam int BEAT_W     = LANES * ELEM_W;

  logic              active_q, start_q, accept;
  logic              cfg_ix_q;
  logic [ADDR_W-1:0] cfg_base_q, cfg_step_q, cfg_idx_q;
  logic [1:0]        cfg_code_q;
  logic [TOT_W-1:0]  cfg_total_q;

  logic              elem_push, elem_pop, fifo_empty;
  logic [ELEM_W-1:0] push_data, pop_data;
  logic [CNT_W-1:0]  fifo_cnt, ag_inflight;

  assign req_ready = !active_q;
  assign accept    = req_valid && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      start_q     <= 1'b0;
      cfg_ix_q    <= 1'b0;
      cfg_base_q  <= '0;
      cfg_step_q  <= '0;
      cfg_idx_q   <= '0;
      cfg_code_q  <= '0;
      cfg_total_q <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        active_q    <= 1'b1;
        cfg_base_q  <= req_base;
        cfg_step_q  <= req_packed ? ADDR_W'(req_step) : ADDR_W'(ELEM_BYTES);
        cfg_ix_q    <= req_packed && req_indexed;
        cfg_code_q  <= req_step[1:0];
        cfg_idx_q   <= req_idx_addr;
        cfg_total_q <= TOT_W'(req_len) + TOT_W'(1);
      end else if (beat_valid && beat_ready && beat_last) begin
        active_q <= 1'b0;
      end
    end
  end

  gp_addr_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_W(MEM_W),
    .ELEM_W(ELEM_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_agen (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .cfg_indexed(cfg_ix_q), .cfg_base(cfg_base_q), .cfg_step(cfg_step_q),
    .cfg_idx_addr(cfg_idx_q), .cfg_idx_code(cfg_code_q), .cfg_total(cfg_total_q),
    .fifo_cnt(fifo_cnt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .elem_push(elem_push), .elem_data(push_data), .inflight(ag_inflight)
  );

  gp_fifo #(.W(ELEM_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(elem_push), .din(push_data),
    .pop(elem_pop), .dout(pop_data),
    .empty(fifo_empty), .count(fifo_cnt)
  );

  gp_beat_pack #(.ELEM_W(ELEM_W), .LANES(LANES), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .start(start_q), .cfg_total(cfg_total_q),
    .elem_avail(!fifo_empty), .elem_data(pop_data), .elem_pop(elem_pop),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .beat_last(beat_last)
  );
endmodule

// File: rtl/gp_checker.sv
module gp_checker #(
  parameter int BEAT_W = 64,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic              beat_last,
  input logic [BEAT_W-1:0] beat_data,
  input logic              elem_push,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [CNT_W-1:0]  ag_inflight
);
  // R1: reset leaves the block idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (req_ready && !beat_valid && !mem_req_valid));

  // R7: busy after acceptance
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: final beat handshake frees the block
  assert_free_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> req_ready);

  // R7: no traffic while idle
  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !beat_valid));

  // R8: stalled beat holds
  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data) && $stable(beat_last)));

  // R9: credit bound between address stage and FIFO
  assert_credit_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ag_inflight} + {1'b0, fifo_cnt}) <= (CNT_W + 1)'(DEPTH));

  // R9: a returning element always finds room
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    elem_push |-> (fifo_cnt < CNT_W'(DEPTH)));
endmodule

bind gather_packer gp_checker #(.BEAT_W(BEAT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid),
  .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_last(beat_last), .beat_data(beat_data),
  .elem_push(elem_push), .fifo_cnt(fifo_cnt), .ag_inflight(ag_inflight)
);

// File: tb/gather_packer_tb_top.sv
module gather_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int EW         = 16;
  localparam int DEPTH      = 4;
  localparam int WD_LIMIT   = 60000;

  typedef struct {
    logic [31:0] base;
    int          len;
    bit          pk;
    bit          ix;
    logic [15:0] step;
    logic [31:0] idx_addr;
    bit          stall;
    string       tag;
  } req_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_packed, req_indexed;
  logic [31:0] req_base, req_idx_addr;
  logic [7:0]  req_len;
  logic [15:0] req_step;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        beat_valid, beat_ready, beat_last;
  logic [63:0] beat_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gather_packer dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_len(req_len),
    .req_packed(req_packed), .req_indexed(req_indexed),
    .req_step(req_step), .req_idx_addr(req_idx_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .beat_last(beat_last)
  );

  logic [7:0]  mem_b [4096];
  req_t        req_q[$];
  logic [31:0] exp_addr[$];
  bit          exp_kind[$];
  logic [63:0] exp_beat[$];
  bit          exp_lastq[$];
  int          exp_cnt[$];
  logic [31:0] rsp_addr[$];
  int          rsp_due[$];

  int    n_checks = 0, n_err = 0, cyc = 0;
  int    el_issued = 0, el_done = 0;
  bit    model_busy = 0, stall_on = 0, finished = 0;
  bit    hold_prev = 0, hold_last;
  logic [63:0] hold_data;
  string cur_tag = "R2";

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem_b[int'((a + 3) & 32'hFFF)], mem_b[int'((a + 2) & 32'hFFF)],
            mem_b[int'((a + 1) & 32'hFFF)], mem_b[int'(a & 32'hFFF)]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // Reference model: expected read addresses and beats of a burst
  task automatic model_accept(input req_t r);
    int n, ib, lane;
    logic [31:0] a, ia, idx, w;
    logic [63:0] bt;
    n = r.len + 1; bt = '0; lane = 0;
    ib = (r.step[1:0] == 2'd0) ? 1 : (r.step[1:0] == 2'd1) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      if (!r.pk) a = r.base + 32'(i * 2);
      else if (!r.ix) a = r.base + 32'(i) * 32'(r.step);
      else begin
        ia = r.idx_addr + 32'(i * ib);
        exp_addr.push_back(ia); exp_kind.push_back(1'b1);
        idx = rd32(ia);
        if (ib == 1) idx &= 32'hFF;
        else if (ib == 2) idx &= 32'hFFFF;
        a = r.base + (idx << 1);
      end
      exp_addr.push_back(a); exp_kind.push_back(1'b0);
      w = rd32(a);
      bt[lane*EW +: EW] = w[EW-1:0];
      lane++;
      if (lane == LANES || i == n - 1) begin
        exp_beat.push_back(bt); exp_lastq.push_back(i == n - 1); exp_cnt.push_back(lane);
        bt = '0; lane = 0;
      end
    end
  endtask

  task automatic add_req(input logic [31:0] base, input int len, input bit pk, input bit ix,
                         input logic [15:0] step, input logic [31:0] ia, input bit stall,
                         input string tag);
    req_t r;
    r.base = base; r.len = len; r.pk = pk; r.ix = ix; r.step = step;
    r.idx_addr = ia; r.stall = stall; r.tag = tag;
    req_q.push_back(r);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_b[i] = 8'((i * 37 + 11) ^ (i >> 7));
    // index arrays: 1-byte at 0x800, 2-byte at 0x900, 4-byte at 0xA00
    for (int i = 0; i < 16; i++) mem_b[32'h800 + i] = 8'(i * 29 + 3);
    for (int i = 0; i < 16; i++) begin
      int v;
      v = (i * 113 + 7) % 1500;
      mem_b[32'h900 + 2*i] = 8'(v); mem_b[32'h900 + 2*i + 1] = 8'(v >> 8);
    end
    for (int i = 0; i < 16; i++) begin
      int v;
      v = (i * 211 + 5) % 1800;
      for (int b = 0; b < 4; b++) mem_b[32'hA00 + 4*i + b] = 8'(v >> (8 * b));
    end

    add_req(32'h100, 7, 0, 1, 16'h33, 32'h800, 0, "R2");   // step, mode bit ignored
    add_req(32'h040, 9, 1, 0, 16'd6, 32'h0, 0, "R3");      // 10 elems, partial beat
    add_req(32'h2A2, 0, 1, 0, 16'd0, 32'h0, 0, "R3");      // single element, zero step
    add_req(32'h000, 5, 1, 1, 16'd0, 32'h800, 0, "R4");    // 1-byte indices
    add_req(32'h010, 3, 1, 1, 16'd1, 32'h900, 0, "R4");    // 2-byte indices
    add_req(32'h000, 6, 1, 1, 16'd2, 32'hA00, 0, "R4");    // 4-byte indices
    add_req(32'h300, 30, 1, 0, 16'd4, 32'h0, 1, "R9");     // long output stall
    add_req(32'h020, 12, 1, 1, 16'd3, 32'hA00, 1, "R9");   // indexed under stall

    rst_n = 1'b0; req_valid = 0; req_base = '0; req_len = '0; req_packed = 0;
    req_indexed = 0; req_step = '0; req_idx_addr = '0; mem_req_ready = 0;
    mem_rsp_valid = 0; mem_rsp_data = '0; beat_ready = 0;

    while (!finished) begin
      @(negedge clk);
      cyc++;
      if (cyc == 6) rst_n = 1'b1;
      req_valid = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      if (rst_n) begin
        if (!model_busy && req_q.size() > 0) begin
          req_valid = 1'b1; req_base = req_q[0].base; req_len = 8'(req_q[0].len);
          req_packed = req_q[0].pk; req_indexed = req_q[0].ix;
          req_step = req_q[0].step; req_idx_addr = req_q[0].idx_addr;
        end
        mem_req_ready = ($urandom % 4) != 0;
        beat_ready = stall_on ? (($urandom % 8) == 0) : (($urandom % 4) != 0);
        if (rsp_addr.size() > 0 && rsp_due[0] <= cyc) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd32(rsp_addr.pop_front());
          void'(rsp_due.pop_front());
        end
      end
      #1;
      if (cyc == 3 || cyc == 6) begin
        chk(req_ready, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(!beat_valid, "R1", "beat_valid after reset", 64'(beat_valid), 64'd0);
        chk(!mem_req_valid, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
      end
      if (!rst_n) continue;

      // R7: busy window as seen at the request port
      chk(req_ready == !model_busy, "R7", "req_ready", 64'(req_ready), 64'(!model_busy));

      // R8: stalled beat frozen
      if (hold_prev)
        chk(beat_valid && beat_data == hold_data && beat_last == hold_last, "R8",
            "held beat", beat_data, hold_data);
      hold_prev = beat_valid && !beat_ready;
      hold_data = beat_data; hold_last = beat_last;

      // R2 R3 R4: address sequence
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr.size() == 0) begin
          chk(0, cur_tag, "unexpected read", 64'(mem_req_addr), 64'd0);
        end else begin
          bit k;
          chk(mem_req_addr == exp_addr[0], cur_tag, "read address", 64'(mem_req_addr),
              64'(exp_addr[0]));
          k = exp_kind[0];
          void'(exp_addr.pop_front()); void'(exp_kind.pop_front());
          if (!k) begin
            el_issued++;
            chk(el_issued - el_done <= DEPTH + LANES, "R9", "elements in flight",
                64'(el_issued - el_done), 64'(DEPTH + LANES));
          end
        end
        rsp_addr.push_back(mem_req_addr);
        rsp_due.push_back(cyc + 1 + int'($urandom % 3));
      end

      // R5 R6: beat contents, padding and last flag
      if (beat_valid && beat_ready) begin
        if (exp_beat.size() == 0) begin
          chk(0, "R7", "beat beyond burst", beat_data, 64'd0);
        end else begin
          chk(beat_data == exp_beat[0], "R5", {"beat data ", cur_tag}, beat_data, exp_beat[0]);
          chk(beat_last == exp_lastq[0], "R6", {"last flag ", cur_tag}, 64'(beat_last),
              64'(exp_lastq[0]));
          el_done += exp_cnt[0];
          void'(exp_beat.pop_front()); void'(exp_lastq.pop_front()); void'(exp_cnt.pop_front());
        end
        if (beat_last) begin
          model_busy = 0;
          stall_on = 0;
          chk(exp_beat.size() == 0 && exp_addr.size() == 0, "R7", "burst element count",
              64'(exp_beat.size() + exp_addr.size()), 64'd0);
        end
      end

      if (req_valid && req_ready) begin
        model_accept(req_q[0]);
        cur_tag = req_q[0].tag;
        stall_on = req_q[0].stall;
        model_busy = 1;
        void'(req_q.pop_front());
      end

      if (cyc > WD_LIMIT) begin
        chk(0, "R7", "watchdog expired", 64'(cyc), 64'(WD_LIMIT));
        finished = 1;
      end
      if (req_q.size() == 0 && !model_busy) finished = 1;
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule